// File: doc/BRIEF.md
# Clock Emergency Handling Controller

This block watches over system clock generation and reacts to two failures: the external input clock slowing down or stopping, and the PLL losing lock. It runs entirely on an always-running backup clock. It oversamples the input clock and counts its rising edges over a fixed window of backup clock cycles. It also filters a synchronised lock indication from the PLL with a programmable low-time limit.

When a failure is seen, the block can do several things. Each action has its own enable:
- steer the system clock multiplexer to an alternate source, and choose which alternate;
- drop the PLL into unlocked mode;
- report status;
- set sticky trap flags and pulse maskable CPU trap requests.

The oscillator, the PLL and the glitch-free multiplexer are outside the block. They appear only as select outputs and status inputs. Software configures the block and clears flags through a small register port with a combinational read path.

The input clock must run below half the backup clock rate, because it is oversampled.

Top module: `clk_emerg_ctrl`

## Requirements
- R1: After reset the main source is selected (`alt_sel_o`=0, `alt_idx_o`=0), PLL normal mode is requested (`pll_unlocked_o`=0), both trap outputs are 0, the status flags are 0, CONFIG reads 0 and LIMITS reads 0x0402.
- R2: Rising edges of `in_clk_i` are counted over windows of WIN_LEN backup cycles. At the end of a window, a count below the threshold (LIMITS[7:0]) declares an input failure. A window whose count reaches the threshold clears the failure.
- R3: During an input failure `alt_sel_o` goes to 1 only when the switch enable CONFIG[0] is 1. It returns to 0 once the failure clears.
- R4: `alt_idx_o` is CONFIG[3:2] when the alternate pick enable CONFIG[1] is 1, and 0 otherwise. It is 0 whenever the main source is selected. STATUS[1] (emergency source) is 1 during an input failure only when CONFIG[1] is 1. STATUS[2] mirrors `alt_sel_o`.
- R5: `pll_valid_o` and STATUS[0] are 0 while an input failure is present. Otherwise they follow the synchronised lock input.
- R6: Loss of lock is declared once the lock input, after two synchroniser flops, has been low for LIMITS[15:8] consecutive cycles (0 acts as 1). `pll_unlocked_o` and STATUS[3] go to 1 on loss of lock only when CONFIG[4] is 1. Both return to 0 when lock returns.
- R7: STATUS[4] (input-failure flag) and STATUS[5] (lock-loss flag) are set on the rising edge of their event. They stay set until a write of 1 to bit 0 or bit 1 of address 2 clears them. An event rising in the same cycle as the clear wins.
- R8: `trap_osc_o` and `trap_vco_o` each give a single-cycle pulse per rising edge of their event. The pulse is issued only when the trap mask CONFIG[5] or CONFIG[6] respectively is 0.
- R9: The register map is as follows:
  - address 0, CONFIG, 7 bits, read/write;
  - address 1, LIMITS, read/write, with the threshold in [7:0] and the lock limit in [15:8];
  - address 2, read as STATUS[5:0] and written as flag clear;
  - address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running backup clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_clk_i | input | 1 | External input clock under supervision |
| pll_lock_i | input | 1 | Asynchronous lock indication from the PLL |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| alt_sel_o | output | 1 | 1 selects an alternate system clock source |
| alt_idx_o | output | 2 | Which alternate source is used |
| pll_unlocked_o | output | 1 | 1 requests PLL unlocked mode, 0 normal mode |
| pll_valid_o | output | 1 | PLL output considered valid |
| trap_osc_o | output | 1 | Input-failure trap request pulse |
| trap_vco_o | output | 1 | Lock-loss trap request pulse |

## Verification
The bench sets the threshold exactly equal to the edge count per window, and then one above it. An off-by-one comparator would declare a failure in the first case or miss it in the second.

It drops the lock input for a few cycles fewer than the limit. A filter that counted from the raw input, or ignored the limit, would fall into unlocked mode during that short drop.

It writes a flag clear in the very cycle that the lock-loss event rises. A design that let the clear win would lose a trap record.

With a masked trap, a design that gated the flag instead of only the request would show an empty flag. A request held for the whole event would show more than one pulse per event.

// File: rtl/ceh_pkg.sv
`timescale 1ns/1ps
package ceh_pkg;
  localparam int unsigned ALT_W = 2;

  // CONFIG register layout, bit 0 = switch_en
  typedef struct packed {
    logic             mask_vco;
    logic             mask_osc;
    logic             fallback_en;
    logic [ALT_W-1:0] pick_idx;
    logic             pick_en;
    logic             switch_en;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_LIM  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam int unsigned STAT_W = 6;
endpackage

// File: rtl/ceh_regs.sv
`timescale 1ns/1ps
module ceh_regs
  import ceh_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned LIM_W   = 8,
  parameter int unsigned THR_RST = 2,
  parameter int unsigned LIM_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg,
  output logic [THR_W-1:0]  thr,
  output logic [LIM_W-1:0]  lim,
  output logic              clr_osc,
  output logic              clr_vco
);
  localparam int unsigned LIMS_W = THR_W + LIM_W;
  localparam int unsigned USED_W = (LIMS_W > CFG_W) ? LIMS_W : CFG_W;

  cfg_t             cfg_q, cfg_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic             wr_cfg, wr_lim, wr_stat;

  assign wr_cfg  = we && (addr == A_CFG);
  assign wr_lim  = we && (addr == A_LIM);
  assign wr_stat = we && (addr == A_STAT);

  always_comb begin
    cfg_d = cfg_q;
    thr_d = thr_q;
    lim_d = lim_q;
    if (wr_cfg) cfg_d = cfg_t'(wdata[CFG_W-1:0]);
    if (wr_lim) begin
      thr_d = wdata[THR_W-1:0];
      lim_d = wdata[LIMS_W-1:THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      thr_q <= THR_W'(THR_RST);
      lim_q <= LIM_W'(LIM_RST);
    end else begin
      cfg_q <= cfg_d;
      thr_q <= thr_d;
      lim_q <= lim_d;
    end
  end

  always_comb begin
    case (addr)
      A_CFG:   rdata = DATA_W'(cfg_q);
      A_LIM:   rdata = DATA_W'({lim_q, thr_q});
      A_STAT:  rdata = DATA_W'(status);
      default: rdata = '0;
    endcase
  end

  assign clr_osc = wr_stat && wdata[0];
  assign clr_vco = wr_stat && wdata[1];
  assign cfg     = cfg_q;
  assign thr     = thr_q;
  assign lim     = lim_q;

  generate
    if (DATA_W > USED_W) begin : g_spare
      logic unused_wdata;
      assign unused_wdata = ^wdata[DATA_W-1:USED_W];
    end
  endgenerate

  AST_LIM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (lim == $past(wdata[LIMS_W-1:THR_W]))); // R9
endmodule

// File: rtl/ceh_osc_mon.sv
`timescale 1ns/1ps
module ceh_osc_mon #(
  parameter int unsigned WIN_LEN = 32,
  parameter int unsigned THR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_clk,
  input  logic [THR_W-1:0] thr,
  output logic             fail
);
  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  logic [2:0]       smp_q;
  logic [WIN_W-1:0] win_q, win_d;
  logic [THR_W-1:0] cnt_q, cnt_d, tot;
  logic             fail_q, fail_d;
  logic             edg, win_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[1:0], in_clk};
  end

  assign edg     = smp_q[1] & ~smp_q[2];
  assign win_end = (win_q == WIN_LAST);

  always_comb begin
    tot    = (edg && (cnt_q != '1)) ? cnt_q + 1'b1 : cnt_q;
    win_d  = win_end ? '0 : win_q + 1'b1;
    cnt_d  = win_end ? '0 : tot;
    fail_d = win_end ? (tot < thr) : fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      fail_q <= fail_d;
    end
  end

  assign fail = fail_q;

  AST_FAIL_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fail_q) |-> $past(win_end)); // R2
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/ceh_lock_mon.sv
`timescale 1ns/1ps
module ceh_lock_mon #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_lock,
  input  logic [LIM_W-1:0] lim,
  output logic             lock_s,
  output logic             lost
);
  logic [1:0]       sync_q;
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             lost_q, lost_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pll_lock};
  end

  assign lock_s = sync_q[1];

  always_comb begin
    if (lock_s)            cnt_d = '0;
    else if (cnt_q == '1)  cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
    lost_d = ~lock_s & (cnt_d >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost = lost_q;

  AST_LOST_DROPS_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_s |=> !lost_q); // R6
endmodule

// File: rtl/ceh_trap.sv
`timescale 1ns/1ps
module ceh_trap (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic mask,
  input  logic clr,
  output logic flag,
  output logic req
);
  logic evt_q, flag_q, flag_d, req_q, req_d, rise;

  assign rise = evt & ~evt_q;

  always_comb begin
    flag_d = rise | (flag_q & ~clr);
    req_d  = rise & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      evt_q  <= evt;
      flag_q <= flag_d;
      req_q  <= req_d;
    end
  end

  assign flag = flag_q;
  assign req  = req_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R8
  AST_REQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !$past(mask)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R7
  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> flag_q); // R7
endmodule

// File: rtl/clk_emerg_ctrl.sv
`timescale 1ns/1ps
module clk_emerg_ctrl
  import ceh_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WIN_LEN = 32,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned LIM_W   = 8,
  parameter int unsigned THR_RST = 2,
  parameter int unsigned LIM_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_clk_i,
  input  logic              pll_lock_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              alt_sel_o,
  output logic [ALT_W-1:0]  alt_idx_o,
  output logic              pll_unlocked_o,
  output logic              pll_valid_o,
  output logic              trap_osc_o,
  output logic              trap_vco_o
);
  localparam int unsigned NTRAP = 2;

  logic [1:0]        rst_q;
  logic              rst_ni;
  cfg_t              cfg;
  logic [THR_W-1:0]  thr;
  logic [LIM_W-1:0]  lim;
  logic              clr_osc, clr_vco;
  logic              osc_fail, lock_s, lost;
  logic [NTRAP-1:0]  t_evt, t_mask, t_clr, t_flag, t_req;
  logic [STAT_W-1:0] status;

  logic             alt_q, alt_d;
  logic [ALT_W-1:0] idx_q, idx_d;
  logic             emerg_q, emerg_d;
  logic             unl_q, unl_d;
  logic             valid_q, valid_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  ceh_regs #(
    .DATA_W(DATA_W), .THR_W(THR_W), .LIM_W(LIM_W),
    .THR_RST(THR_RST), .LIM_RST(LIM_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_ni), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .status(status), .rdata(reg_rdata_o),
    .cfg(cfg), .thr(thr), .lim(lim), .clr_osc(clr_osc), .clr_vco(clr_vco)
  );

  ceh_osc_mon #(.WIN_LEN(WIN_LEN), .THR_W(THR_W)) u_osc (
    .clk(clk), .rst_n(rst_ni), .in_clk(in_clk_i), .thr(thr), .fail(osc_fail)
  );

  ceh_lock_mon #(.LIM_W(LIM_W)) u_lock (
    .clk(clk), .rst_n(rst_ni), .pll_lock(pll_lock_i), .lim(lim),
    .lock_s(lock_s), .lost(lost)
  );

  // trap slot 0: input failure, slot 1: lock loss
  assign t_evt  = {lost, osc_fail};
  assign t_mask = {cfg.mask_vco, cfg.mask_osc};
  assign t_clr  = {clr_vco, clr_osc};

  generate
    for (genvar g = 0; g < NTRAP; g++) begin : g_trap
      ceh_trap u_trap (
        .clk(clk), .rst_n(rst_ni), .evt(t_evt[g]), .mask(t_mask[g]),
        .clr(t_clr[g]), .flag(t_flag[g]), .req(t_req[g])
      );
    end
  endgenerate

  always_comb begin
    alt_d   = osc_fail & cfg.switch_en;
    idx_d   = (alt_d && cfg.pick_en) ? cfg.pick_idx : '0;
    emerg_d = osc_fail & cfg.pick_en;
    unl_d   = lost & cfg.fallback_en;
    valid_d = lock_s & ~osc_fail;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_q   <= 1'b0;
      idx_q   <= '0;
      emerg_q <= 1'b0;
      unl_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      alt_q   <= alt_d;
      idx_q   <= idx_d;
      emerg_q <= emerg_d;
      unl_q   <= unl_d;
      valid_q <= valid_d;
    end
  end

  assign status         = {t_flag[1], t_flag[0], unl_q, alt_q, emerg_q, valid_q};
  assign alt_sel_o      = alt_q;
  assign alt_idx_o      = idx_q;
  assign pll_unlocked_o = unl_q;
  assign pll_valid_o    = valid_q;
  assign trap_osc_o     = t_req[0];
  assign trap_vco_o     = t_req[1];

  AST_ALT_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_ni)
    alt_sel_o |-> $past(osc_fail)); // R3
  AST_IDX_ZERO_ON_MAIN: assert property (@(posedge clk) disable iff (!rst_ni)
    !alt_sel_o |-> (alt_idx_o == '0)); // R4
  AST_VALID_LOW_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_ni)
    osc_fail |=> !pll_valid_o); // R5
  AST_UNLOCK_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_ni)
    pll_unlocked_o |-> $past(lost)); // R6
endmodule

// File: tb/clk_emerg_ctrl_tb.sv
`timescale 1ns/1ps
module clk_emerg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_clk, run;
  logic        lock;
  logic        we;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        alt_sel, unl, valid, t_osc, t_vco;
  logic [1:0]  alt_idx;

  int total = 0;
  int bad   = 0;
  int n_osc = 0;
  int n_vco = 0;
  bit unl_seen = 1'b0;
  logic [31:0] d;

  always #4 clk = ~clk;

  clk_emerg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_clk_i(in_clk), .pll_lock_i(lock),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .alt_sel_o(alt_sel), .alt_idx_o(alt_idx), .pll_unlocked_o(unl),
    .pll_valid_o(valid), .trap_osc_o(t_osc), .trap_vco_o(t_vco)
  );

  // input clock: period 8 backup cycles => 4 rising edges per 32-cycle window
  initial begin
    in_clk = 1'b0;
    forever begin
      repeat (4) @(negedge clk);
      if (run) in_clk = ~in_clk;
    end
  end

  always @(negedge clk) begin
    if (t_osc) n_osc++;
    if (t_vco) n_vco++;
    if (unl) unl_seen = 1'b1;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = rdata;
  endtask

  // {cfg[7:0], run, lock, wait[7:0], status[3:0], alt, idx[1:0], unl, pad[5:0]}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 1'b1, 1'b1, 8'd80,  4'b0001, 1'b0, 2'd0, 1'b0, 6'd0},
    {8'h01, 1'b0, 1'b1, 8'd100, 4'b0100, 1'b1, 2'd0, 1'b0, 6'd0},
    {8'h0F, 1'b0, 1'b1, 8'd100, 4'b0110, 1'b1, 2'd3, 1'b0, 6'd0},
    {8'h0E, 1'b0, 1'b1, 8'd100, 4'b0010, 1'b0, 2'd0, 1'b0, 6'd0},
    {8'h0F, 1'b1, 1'b1, 8'd100, 4'b0001, 1'b0, 2'd0, 1'b0, 6'd0},
    {8'h10, 1'b1, 1'b0, 8'd40,  4'b1000, 1'b0, 2'd0, 1'b1, 6'd0},
    {8'h00, 1'b1, 1'b0, 8'd40,  4'b0000, 1'b0, 2'd0, 1'b0, 6'd0},
    {8'h10, 1'b1, 1'b1, 8'd20,  4'b0001, 1'b0, 2'd0, 1'b0, 6'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b1; lock = 1'b1;
    we = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "alt_sel", 32'(alt_sel), 32'd0);
    chk("R1", "alt_idx", 32'(alt_idx), 32'd0);
    chk("R1", "pll_unlocked", 32'(unl), 32'd0);
    chk("R1", "traps", 32'({t_vco, t_osc}), 32'd0);
    rd(2'd2, d); chk("R1", "flags", 32'(d[5:4]), 32'd0);
    rd(2'd0, d); chk("R1", "config", d, 32'd0);
    rd(2'd1, d); chk("R1", "limits", d, 32'h0402);
    rd(2'd3, d); chk("R9", "addr3", d, 32'd0);

    // vector table: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      wr(2'd0, {24'd0, v[31:24]});
      run  = v[23];
      lock = v[22];
      repeat (int'(v[21:14])) @(negedge clk);
      rd(2'd2, d);
      chk("R3/R4/R5/R6", $sformatf("vec%0d status", i), 32'(d[3:0]), 32'(v[13:10]));
      chk("R3", $sformatf("vec%0d alt_sel", i), 32'(alt_sel), 32'(v[9]));
      chk("R4", $sformatf("vec%0d alt_idx", i), 32'(alt_idx), 32'(v[8:7]));
      chk("R6", $sformatf("vec%0d unlocked", i), 32'(unl), 32'(v[6]));
      chk("R5", $sformatf("vec%0d pll_valid", i), 32'(valid), 32'(d[0]));
    end

    lock = 1'b1; run = 1'b1;
    wr(2'd0, 32'h0);
    repeat (100) @(negedge clk);
    wr(2'd2, 32'h3);

    // R8 masked input-failure trap, R7 flag still recorded and W1C
    wr(2'd0, 32'h20);
    n_osc = 0; run = 1'b0;
    repeat (120) @(negedge clk);
    chk("R8", "masked osc pulses", 32'(n_osc), 32'd0);
    rd(2'd2, d); chk("R7", "osc flag set while masked", 32'(d[4]), 32'd1);
    wr(2'd2, 32'h1);
    rd(2'd2, d); chk("R7", "osc flag cleared", 32'(d[4]), 32'd0);
    run = 1'b1;
    repeat (100) @(negedge clk);
    wr(2'd0, 32'h0);
    n_osc = 0; run = 1'b0;
    repeat (120) @(negedge clk);
    chk("R8", "unmasked osc pulses", 32'(n_osc), 32'd1);
    run = 1'b1;
    repeat (100) @(negedge clk);

    // R2 threshold boundary: 4 edges per window
    wr(2'd1, 32'h0404);
    rd(2'd1, d); chk("R9", "limits readback", d, 32'h0404);
    repeat (100) @(negedge clk);
    rd(2'd2, d); chk("R2", "thr=count no fail", 32'(d[0]), 32'd1);
    wr(2'd1, 32'h0405);
    repeat (100) @(negedge clk);
    rd(2'd2, d); chk("R2", "thr=count+1 fail", 32'(d[0]), 32'd0);
    wr(2'd1, 32'h0404);
    repeat (100) @(negedge clk);
    rd(2'd2, d); chk("R2", "recovered", 32'(d[0]), 32'd1);

    // R6 lock filter limit
    wr(2'd1, 32'h0A02);
    wr(2'd0, 32'h10);
    repeat (5) @(negedge clk);
    unl_seen = 1'b0;
    lock = 1'b0;
    repeat (8) @(negedge clk);
    lock = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6", "short drop ignored", 32'(unl_seen), 32'd0);
    lock = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6", "long drop unlocked", 32'(unl), 32'd1);
    lock = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6", "relock normal", 32'(unl), 32'd0);

    // R7 event beats same-cycle clear (limit 1)
    wr(2'd1, 32'h0102);
    wr(2'd2, 32'h2);
    repeat (5) @(negedge clk);
    n_vco = 0;
    lock = 1'b0;
    repeat (3) @(negedge clk);
    we = 1'b1; addr = 2'd2; wdata = 32'h2;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    rd(2'd2, d); chk("R7", "event wins over clear", 32'(d[5]), 32'd1);
    chk("R8", "vco single pulse", 32'(n_vco), 32'd1);
    lock = 1'b1;
    repeat (5) @(negedge clk);
    wr(2'd2, 32'h2);
    rd(2'd2, d); chk("R7", "vco flag cleared", 32'(d[5]), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule